// File: doc/BRIEF.md
# Three-Source Pin Interrupt Controller

This block turns three external pin inputs into interrupt requests for a processor. The two lower sources each take a two-bit sense code that selects low-level, any-change, falling-edge or rising-edge detection. They are sampled on the system clock through a two-flop synchroniser, and edges are found by comparing consecutive samples. The top source is edge-only. A flop clocked by the pin itself records its edge, so the edge is captured even while the system clock is stopped. The recorded edge is then synchronised into the clock domain once the clock runs again.

Edge sources latch a pending flag. The flag stays set until the processor acknowledges that source or software writes 1 to its bit. A source in low-level mode has no latched flag: its request follows the synchronised pin. Each request reaches `irq_req` only when the global enable input and the source's mask bit are both set. A separate qualifier runs on a slow watchdog-oscillator clock. It raises a wake signal when an enabled low-level source is seen low on two consecutive slow-clock samples. If the level has gone before the processor is running, the request has gone too, so the processor wakes but takes no interrupt.

Software reaches the sense codes, a free four-bit field, the masks, the polarity of the top source and the pending flags through a small register port.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, `irq_req` and `lvl_wake` are 0 and the registers read 0: control at address 0, mask at address 1, pending at address 2.
- R2: Control register bits [1:0] hold the sense code of source 0 and bits [3:2] that of source 1: 00 low level, 01 any change, 10 falling edge, 11 rising edge. An edge of the unselected polarity sets nothing. Bits [7:4] are plain read/write storage. Reads return the value of `reg_addr` one cycle after it is presented.
- R3: In low-level mode a source requests while its pin is low and stops once the pin is high again, and its pending bit stays 0.
- R4: A selected edge sets the source's pending bit (address 2, bit i). The bit and the request remain set after the pin returns to its idle level.
- R5: `irq_req[i]` is 1 only if `gie` was 1 and mask bit i (address 1, bit i) was 1 in the previous cycle.
- R6: A 1 on `ack[i]` clears pending bit i. So does writing 1 to bit i of address 2.
- R7: If a new edge and a clear of the same source fall in the same cycle, the flag stays set.
- R8: A pulse on source 0 or 1 that lasts longer than one clock period produces an interrupt.
- R9: Source 2 is edge-only. Address 1 bit 3 selects its polarity (0 falling, 1 rising). An edge that arrives while the clock is stopped sets its pending bit once the clock runs.
- R10: `lvl_wake` rises only after an enabled low-level source of 0 or 1 is seen low on two consecutive `wdt_clk` rising edges. It falls at the first `wdt_clk` sample after the pin goes high. A low level that spans just one sample never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (I/O) clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_clk | input | 1 | Slow watchdog-oscillator clock for level wake qualification |
| gie | input | 1 | Global interrupt enable from the processor |
| pin | input | 3 | Interrupt pins; bits 0 and 1 are sense-selectable, bit 2 is edge-only |
| ack | input | 3 | Per-source acknowledge; a 1 clears that pending flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 mask, 2 pending |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_req | output | 3 | Per-source interrupt request, registered |
| lvl_wake | output | 1 | Wake request from a qualified low level |

## Verification
Edge detection and acknowledge can land on the same clock edge, and the block must then keep the flag set. The bench provokes this by counting the two synchroniser edges after a pin change and raising `ack` for exactly the third edge, the one on which the detected edge is latched. It then expects `irq_req` still high, and expects a later ack on its own to clear it. The top source is tested the same way around a stopped clock: its edge arrives with no clock running, and the bench checks for the request after restart.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_PEND = 2;
endpackage

// File: rtl/xirq_sync_src.sv
module xirq_sync_src
  import xirq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   hit_o,
  output logic   flag_o,
  output logic   active_o
);
  logic [STAGES-1:0] sh;
  logic prev;
  logic cur;

  assign cur = sh[STAGES-1];

  // pins idle high, so the chain resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], pin_i};
      prev <= cur;
    end
  end

  always_comb begin
    unique case (mode_i)
      SNS_ANY:  hit_o = prev ^ cur;
      SNS_FALL: hit_o = prev & ~cur;
      SNS_RISE: hit_o = ~prev & cur;
      default:  hit_o = 1'b0;
    endcase
  end

  // a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (hit_o) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign active_o = (mode_i == SNS_LOW) ? ~cur : flag_o;
endmodule

// File: rtl/xirq_async_src.sv
module xirq_async_src #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_o
);
  logic edge_clk;
  logic tog = 1'b0;
  logic [STAGES-1:0] sh = '0;
  logic hist = 1'b0;

  // the selected pin edge clocks a toggle flop; no system clock needed
  assign edge_clk = pin_i ^ ~rise_i;

  always_ff @(posedge edge_clk) tog <= ~tog;

  always_ff @(posedge clk) begin
    sh   <= {sh[STAGES-2:0], tog};
    hist <= sh[STAGES-1];
  end

  assign hit_o = ~rst & (hist ^ sh[STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (hit_o) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/xirq_lvl_wake.sv
module xirq_lvl_wake #(
  parameter int N = 2
) (
  input  logic         wclk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] en_i,
  output logic         wake_o
);
  logic [N-1:0] low_once;

  always_ff @(posedge wclk) begin
    if (rst) begin
      low_once <= '0;
      wake_o   <= 1'b0;
    end else begin
      low_once <= ~pin_i;
      wake_o   <= |(en_i & low_once & ~pin_i);
    end
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [DW-1:0]   ctrl_q,
  output logic [NSRC-1:0] mask_q,
  output logic            pol_q,
  output logic [NSRC-1:0] w1c_o,
  output logic [DW-1:0]   rdata_o
);
  logic sel_ctrl, sel_mask, sel_pend;

  assign sel_ctrl = (int'(addr_i) == ADDR_CTRL);
  assign sel_mask = (int'(addr_i) == ADDR_MASK);
  assign sel_pend = (int'(addr_i) == ADDR_PEND);

  assign w1c_o = (we_i && sel_pend) ? wdata_i[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      pol_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (we_i && sel_ctrl) ctrl_q <= wdata_i;
      if (we_i && sel_mask) begin
        mask_q <= wdata_i[NSRC-1:0];
        pol_q  <= wdata_i[NSRC];
      end
      if (sel_ctrl)      rdata_o <= ctrl_q;
      else if (sel_mask) rdata_o <= DW'({pol_q, mask_q});
      else if (sel_pend) rdata_o <= DW'(pend_i);
      else               rdata_o <= '0;
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int N_SYNC      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8,
  parameter int AW          = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wdt_clk,
  input  logic            gie,
  input  logic [N_SYNC:0] pin,
  input  logic [N_SYNC:0] ack,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [N_SYNC:0] irq_req,
  output logic            lvl_wake
);
  localparam int NSRC = N_SYNC + 1;

  logic [DW-1:0]     ctrl_q;
  logic [NSRC-1:0]   mask_q;
  logic              pol_q;
  logic [NSRC-1:0]   w1c;
  logic [NSRC-1:0]   clr;
  logic [NSRC-1:0]   src_hit;
  logic [NSRC-1:0]   src_flag;
  logic [NSRC-1:0]   src_active;
  logic [N_SYNC-1:0] lvl_en;

  assign clr = ack | w1c;

  xirq_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .pend_i  (src_flag),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q),
    .pol_q   (pol_q),
    .w1c_o   (w1c),
    .rdata_o (reg_rdata)
  );

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    sense_e mode;
    assign mode      = sense_e'(ctrl_q[2*g+1:2*g]);
    assign lvl_en[g] = mask_q[g] & (mode == SNS_LOW);

    xirq_sync_src #(.STAGES(SYNC_STAGES)) u_src (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (pin[g]),
      .mode_i   (mode),
      .clr_i    (clr[g]),
      .hit_o    (src_hit[g]),
      .flag_o   (src_flag[g]),
      .active_o (src_active[g])
    );
  end

  xirq_async_src #(.STAGES(SYNC_STAGES)) u_asrc (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin[N_SYNC]),
    .rise_i (pol_q),
    .clr_i  (clr[N_SYNC]),
    .hit_o  (src_hit[N_SYNC]),
    .flag_o (src_flag[N_SYNC])
  );
  assign src_active[N_SYNC] = src_flag[N_SYNC];

  xirq_lvl_wake #(.N(N_SYNC)) u_wake (
    .wclk   (wdt_clk),
    .rst    (rst),
    .pin_i  (pin[N_SYNC-1:0]),
    .en_i   (lvl_en),
    .wake_o (lvl_wake)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= gie ? (mask_q & src_active) : '0;
  end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int N_SYNC = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            wdt_clk,
  input logic            gie,
  input logic [N_SYNC:0] pin,
  input logic [N_SYNC:0] irq_req,
  input logic            lvl_wake,
  input logic [N_SYNC:0] mask_q,
  input logic [N_SYNC:0] src_hit,
  input logic [N_SYNC:0] src_flag,
  input logic [N_SYNC:0] clr
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_idle_R1: assert (irq_req == '0)
        else $error("request active after reset");
    end
  end

  assert_gate_gie_R5: assert property (@(posedge clk) disable iff (rst)
    !gie |=> (irq_req == '0));

  for (genvar i = 0; i <= N_SYNC; i++) begin : g_src
    assert_gate_mask_R5: assert property (@(posedge clk) disable iff (rst)
      !mask_q[i] |=> !irq_req[i]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      src_hit[i] |=> src_flag[i]);

    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (rst)
      (src_flag[i] && clr[i] && !src_hit[i]) |=> !src_flag[i]);
  end

  assert_wake_two_samples_R10: assert property (@(posedge wdt_clk) disable iff (rst)
    $rose(lvl_wake) |-> |($past(~pin[N_SYNC-1:0]) & $past(~pin[N_SYNC-1:0], 2)));
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.N_SYNC(N_SYNC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wdt_clk  (wdt_clk),
  .gie      (gie),
  .pin      (pin),
  .irq_req  (irq_req),
  .lvl_wake (lvl_wake),
  .mask_q   (mask_q),
  .src_hit  (src_hit),
  .src_flag (src_flag),
  .clr      (clr)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       wdt_clk = 1'b0;
  logic       rst = 1'b1;
  logic       gie = 1'b0;
  logic [2:0] pin = 3'b111;
  logic [2:0] ack = 3'b000;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] irq_req;
  logic       lvl_wake;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    int         kind;   // 0 irq, 1 read data, 2 wake
    logic [7:0] exp;
  } item_t;

  item_t exp_q[$];
  item_t cur_it;
  logic [7:0] act_v;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst(rst), .wdt_clk(wdt_clk), .gie(gie), .pin(pin), .ack(ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .lvl_wake(lvl_wake)
  );

  always #5 clk = clk_run ? ~clk : 1'b0;

  initial begin
    #3;
    forever #80 wdt_clk = ~wdt_clk;
  end

  // monitor: compares queued expectations just after a falling edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      cur_it = exp_q.pop_front();
      case (cur_it.kind)
        0:       act_v = {5'd0, irq_req};
        1:       act_v = reg_rdata;
        default: act_v = {7'd0, lvl_wake};
      endcase
      n_checks++;
      if (act_v !== cur_it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", cur_it.tag, act_v, cur_it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic pulse_ack(input logic [2:0] v);
    ack = v;
    tick(1);
    ack = 3'b000;
  endtask

  task automatic exp_irq(input string tag, input logic [2:0] v);
    item_t it;
    it.tag = tag; it.kind = 0; it.exp = {5'd0, v};
    exp_q.push_back(it);
  endtask

  task automatic exp_rd(input string tag, input logic [1:0] a, input logic [7:0] v);
    item_t it;
    reg_addr = a;
    tick(1);
    it.tag = tag; it.kind = 1; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic exp_wake(input string tag, input logic v);
    item_t it;
    it.tag = tag; it.kind = 2; it.exp = {7'd0, v};
    exp_q.push_back(it);
  endtask

  initial begin
    tick(30);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    exp_irq("R1 irq after reset", 3'b000);
    exp_wake("R1 wake after reset", 1'b0);
    exp_rd("R1 control reset", 2'd0, 8'h00);
    exp_rd("R1 mask reset", 2'd1, 8'h00);
    exp_rd("R1 pending reset", 2'd2, 8'h00);

    // R2 src0 falling, src1 any change, free field 1010
    wr(2'd0, 8'hA6);
    exp_rd("R2 control readback", 2'd0, 8'hA6);
    gie = 1'b1;
    wr(2'd1, 8'h03);
    pin[0] = 1'b0; tick(5);
    exp_irq("R4 falling edge request", 3'b001);
    exp_rd("R4 pending bit set", 2'd2, 8'h01);
    pin[0] = 1'b1; tick(5);
    exp_irq("R4 request held after idle", 3'b001);
    pulse_ack(3'b001); tick(2);
    exp_irq("R6 ack clears", 3'b000);

    pin[1] = 1'b0; tick(5);
    exp_irq("R2 any-change fall", 3'b010);
    wr(2'd2, 8'h02); tick(3);
    exp_irq("R6 write-one clear", 3'b000);
    pin[1] = 1'b1; tick(5);
    exp_irq("R2 any-change rise", 3'b010);
    wr(2'd2, 8'h02); tick(3);

    // R2 src0 rising, src1 low level
    wr(2'd0, 8'h03); tick(2);
    exp_irq("R3 level source idle high", 3'b000);
    pin[0] = 1'b0; tick(5);
    exp_irq("R2 falling ignored in rise mode", 3'b000);
    exp_rd("R2 no pending from wrong edge", 2'd2, 8'h00);
    pin[0] = 1'b1; tick(5);
    exp_irq("R2 rising edge request", 3'b001);
    pulse_ack(3'b001); tick(3);

    // R3 level mode follows pin
    pin[1] = 1'b0; tick(4);
    exp_irq("R3 level low requests", 3'b010);
    exp_rd("R3 level leaves no flag", 2'd2, 8'h00);
    pin[1] = 1'b1; tick(4);
    exp_irq("R3 level released", 3'b000);

    // R5 mask and global enable
    wr(2'd1, 8'h01);
    pin[1] = 1'b0; tick(4);
    exp_irq("R5 masked source silent", 3'b000);
    wr(2'd1, 8'h03);
    gie = 1'b0; tick(3);
    exp_irq("R5 global enable off", 3'b000);
    gie = 1'b1; tick(3);
    exp_irq("R5 global enable on", 3'b010);
    pin[1] = 1'b1; tick(4);

    // R7 edge and ack on the same clock edge
    pin[0] = 1'b0; tick(5);
    pin[0] = 1'b1; tick(5);
    exp_irq("R7 prior flag set", 3'b001);
    pin[0] = 1'b0; tick(5);
    pin[0] = 1'b1;
    tick(2);
    ack = 3'b001;
    tick(1);
    ack = 3'b000;
    tick(2);
    exp_irq("R7 set wins over ack", 3'b001);
    pulse_ack(3'b001); tick(2);
    exp_irq("R6 lone ack clears", 3'b000);

    // R8 pulse of just over one clock period
    wr(2'd0, 8'h02); tick(1);
    pin[0] = 1'b0; #12; pin[0] = 1'b1;
    tick(5);
    exp_irq("R8 short pulse caught", 3'b001);
    pulse_ack(3'b001); tick(3);

    // R9 source 2: falling first, then rising while clock stopped
    wr(2'd1, 8'h00);
    pin[2] = 1'b0; tick(5);
    exp_rd("R9 falling polarity pends", 2'd2, 8'h04);
    wr(2'd2, 8'h04);
    wr(2'd1, 8'h0C); tick(3);
    exp_irq("R9 nothing pending", 3'b000);
    clk_run = 1'b0;
    #22; pin[2] = 1'b1; #4; pin[2] = 1'b0; #22;
    clk_run = 1'b1;
    tick(6);
    exp_irq("R9 edge during stopped clock", 3'b100);
    exp_rd("R9 pending after restart", 2'd2, 8'h04);
    wr(2'd2, 8'h04); tick(3);
    exp_irq("R9 falling ignored in rise mode", 3'b000);

    // R10 level wake on the slow clock
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    pin[0] = 1'b0;
    #400; tick(1);
    exp_wake("R10 wake after two low samples", 1'b1);
    pin[0] = 1'b1;
    #200; tick(1);
    exp_wake("R10 wake released", 1'b0);
    @(posedge wdt_clk);
    #100; pin[0] = 1'b0;
    #120; pin[0] = 1'b1;
    tick(1);
    exp_wake("R10 single sample no wake", 1'b0);
    #400; tick(1);
    exp_wake("R10 still no wake", 1'b0);

    tick(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule